// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block connects a synchronous request/acknowledge bus inside a chip to an external asynchronous static RAM of 512K bytes. The RAM has active-low chip select, output enable and write strobe pins and a shared 8-bit data bus. The client presents a 19-bit address, a byte of write data and a direction flag. The controller accepts one transaction at a time. It sequences the RAM strobes so that the memory's selection rules and minimum timing are met, and for a read it returns the captured byte together with a one-cycle valid pulse.

All memory timing is given as nanosecond parameters. Each one is turned into a whole number of clock cycles by rounding up the ratio to the clock period, with a floor of one cycle. The data pad is split into an output value, a drive enable and an input value, so that the tristate buffer itself sits in the pad ring. The controller never enables its drivers while the RAM may be driving, and it leaves a turnaround gap after each read. A standby input parks the RAM deselected for low-power retention. Leaving standby, and leaving reset, costs a recovery lockout of one read-cycle time before the next access may start.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after reset, mem_ce_n, mem_oe_n and mem_we_n are 1 and mem_dq_oe, req_ack and rd_valid are 0. Reset is treated like leaving standby: with standby low, the first req_ack comes RC_C+2 rising edges after reset is released.
- R2: A write is accepted with req_write=1. In the cycle after the accepting edge, req_ack is 1 for exactly one cycle. From the accepting edge onward, mem_we_n is 0 for exactly WR_C cycles, where WR_C = max(ceil(WP_NS/CLK_NS), ceil(DS_NS/CLK_NS)). During those cycles mem_ce_n=0, mem_oe_n=1 and mem_dq_oe=1, and mem_addr and mem_dq_out hold the request's address and data.
- R3: A write ends with mem_we_n rising while mem_ce_n stays 0. Address and data are unchanged up to that edge, and after it mem_dq_oe is 0.
- R4: A read is accepted with req_write=0. The cycle that shows req_ack has mem_oe_n=1 and mem_dq_oe=0. Then mem_oe_n is 0 for AA_C = ceil(AA_NS/CLK_NS) cycles. mem_dq_in is captured at the end of the last of these cycles, and rd_valid is 1 with that byte on rd_data for one cycle, AA_C+1 cycles after the req_ack cycle.
- R5: mem_dq_oe and mem_oe_n=0 are never true together. mem_dq_oe is 0 in the cycle before mem_oe_n falls. After mem_oe_n rises, mem_dq_oe stays 0 for at least TA_C = ceil(TURN_NS/CLK_NS) cycles.
- R6: When idle and not in standby, the RAM is selected but quiet: mem_ce_n=0, mem_oe_n=1, mem_we_n=1 and mem_dq_oe=0.
- R7: Only one transaction is outstanding at a time. A request held through a busy period is accepted on the first edge after the controller is back in idle. For a read followed at once by a held request, the second req_ack comes AA_C+TA_C+2 cycles after the first.
- R8: standby sampled high in idle drives mem_ce_n to 1 on the next edge. While standby is high no request is accepted, even one already waiting, and stored data survives the standby period.
- R9: After standby is seen low, mem_ce_n stays 1 and requests wait for RC_C = ceil(RC_NS/CLK_NS) cycles of recovery. A waiting request is acknowledged RC_C+2 edges after the first edge that sees standby low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until req_ack |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| req_ack | output | 1 | One-cycle pulse: request accepted |
| rd_data | output | DATA_W | Captured read byte |
| rd_valid | output | 1 | One-cycle pulse: rd_data valid |
| standby | input | 1 | Park the RAM deselected |
| mem_addr | output | ADDR_W | RAM address pins |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_dq_out | output | DATA_W | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Value read from the data bus |

## Verification
The bench models the RAM so that read data turns valid only after output enable has been low for the full access window. A controller that captures one cycle early therefore returns a junk byte. The bench flags any cycle in which the controller and the model RAM drive the bus together, so a missing release gap or turnaround gap is caught. It counts the write strobe width and the latency to rd_valid exactly, which exposes an off-by-one in any timer. It presents requests during standby and recovery, so a controller that skips the lockout, or lets standby lose to a waiting request, acknowledges too early.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_PARK,
    ST_RECOVER,
    ST_IDLE,
    ST_WRITE,
    ST_RD_GAP,
    ST_RD_ACC,
    ST_TURN
  } ctrl_state_t;

  // Round a nanosecond limit up to whole clock cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  // Address and write data are latched on the accepting edge and held
  // for the whole access, which gives zero setup and generous hold.
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      dq_out   <= '0;
    end else if (accept) begin
      mem_addr <= addr_in;
      dq_out   <= wdata_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= capture;
      if (capture) begin
        rd_data <= dq_in;
      end
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 10,
  parameter int WP_NS   = 17,
  parameter int DS_NS   = 12,
  parameter int AA_NS   = 25,
  parameter int TURN_NS = 10,
  parameter int RC_NS   = 25
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ack,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  input  logic              standby,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int WR_C  = imax(ns_to_cyc(WP_NS, CLK_NS), ns_to_cyc(DS_NS, CLK_NS));
  localparam int AA_C  = ns_to_cyc(AA_NS, CLK_NS);
  localparam int TA_C  = ns_to_cyc(TURN_NS, CLK_NS);
  localparam int RC_C  = ns_to_cyc(RC_NS, CLK_NS);
  localparam int MAX_C = imax(imax(WR_C, AA_C), imax(TA_C, RC_C));
  localparam int CNT_W = $clog2(MAX_C + 1);

  ctrl_state_t      state_q, state_d;
  logic             t_load, t_zero;
  logic [CNT_W-1:0] t_val;
  logic             accept, capture;

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .zero     (t_zero)
  );

  sram_dq_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dq (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .addr_in  (req_addr),
    .wdata_in (req_wdata),
    .capture  (capture),
    .dq_in    (mem_dq_in),
    .mem_addr (mem_addr),
    .dq_out   (mem_dq_out),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  // Each timed state lasts exactly N cycles: the timer is loaded with N-1
  // on entry and the state is left when it reads zero.
  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    accept  = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      ST_PARK: begin
        if (!standby) begin
          state_d = ST_RECOVER;
          t_load  = 1'b1;
          t_val   = CNT_W'(RC_C - 1);
        end
      end
      ST_RECOVER: begin
        if (t_zero) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (standby) begin
          state_d = ST_PARK;
        end else if (req_valid) begin
          accept = 1'b1;
          if (req_write) begin
            state_d = ST_WRITE;
            t_load  = 1'b1;
            t_val   = CNT_W'(WR_C - 1);
          end else begin
            state_d = ST_RD_GAP;
          end
        end
      end
      ST_WRITE: begin
        if (t_zero) state_d = ST_IDLE;
      end
      ST_RD_GAP: begin
        state_d = ST_RD_ACC;
        t_load  = 1'b1;
        t_val   = CNT_W'(AA_C - 1);
      end
      ST_RD_ACC: begin
        if (t_zero) begin
          capture = 1'b1;
          state_d = ST_TURN;
          t_load  = 1'b1;
          t_val   = CNT_W'(TA_C - 1);
        end
      end
      ST_TURN: begin
        if (t_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_PARK;
    endcase
  end

  // Strobes are registered decodes of the next state, so they are glitch
  // free and always match the current state.
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_PARK;
      mem_ce_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      req_ack   <= 1'b0;
    end else begin
      state_q   <= state_d;
      mem_ce_n  <= (state_d == ST_PARK) || (state_d == ST_RECOVER);
      mem_oe_n  <= (state_d != ST_RD_ACC);
      mem_we_n  <= (state_d != ST_WRITE);
      mem_dq_oe <= (state_d == ST_WRITE);
      req_ack   <= accept;
    end
  end

  p_no_contention_r5: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);

  p_release_before_oe_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_oe_n) |-> !$past(mem_dq_oe));

  p_write_selected_r2: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

  p_we_ends_first_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> !mem_ce_n);

  p_rdvalid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);

  p_park_deselect_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PARK) |-> (mem_ce_n && !req_ack));

endmodule

// File: tb/sim_sram_ctrl.sv
`timescale 1ns/1ps
module sim_sram_ctrl;

  localparam int CLK_NS = 10;
  localparam int WRC = 2;   // max(ceil(17/10), ceil(12/10))
  localparam int AAC = 3;   // ceil(25/10)
  localparam int TAC = 1;   // ceil(10/10)
  localparam int RCC = 3;   // ceil(25/10)

  typedef struct packed {
    logic        wr;
    logic [18:0] a;
    logic [7:0]  d;
  } vec_t;

  localparam vec_t VECS [0:7] = '{
    '{1'b1, 19'h00000, 8'h3C},
    '{1'b1, 19'h7FFFF, 8'hC3},
    '{1'b1, 19'h12345, 8'h5A},
    '{1'b0, 19'h7FFFF, 8'hC3},
    '{1'b1, 19'h12345, 8'hE1},
    '{1'b0, 19'h00000, 8'h3C},
    '{1'b0, 19'h12345, 8'hE1},
    '{1'b0, 19'h40000, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, standby = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ack, rd_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  rd_data, mem_dq_out, mem_dq_in;
  logic [18:0] mem_addr;

  int tests = 0, fails = 0;
  bit done = 0;
  int clash = 0;

  always #5 clk = ~clk;

  sram_ctrl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack),
    .rd_data(rd_data), .rd_valid(rd_valid), .standby(standby),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // RAM model: data turns valid only once output enable has been low for AAC cycles.
  logic [7:0] ram [bit [18:0]];
  int         oe_cnt = 0;
  logic       pend = 0;
  logic [18:0] paddr;
  logic [7:0]  pdata;
  wire ram_drive = !mem_ce_n && !mem_oe_n && mem_we_n;

  function automatic logic [7:0] ram_rd(input logic [18:0] a);
    if (ram.exists(a)) return ram[a];
    return 8'h00;
  endfunction

  assign mem_dq_in = (ram_drive && oe_cnt >= AAC - 1) ? ram_rd(mem_addr) : 8'hA5;

  always @(posedge clk) begin
    oe_cnt <= ram_drive ? oe_cnt + 1 : 0;
    if (!mem_ce_n && !mem_we_n) begin
      pend  <= 1'b1;
      paddr <= mem_addr;
      pdata <= mem_dq_out;
    end else if (pend) begin
      ram[paddr] = pdata;
      pend <= 1'b0;
    end
  end

  always @(negedge clk) if (!rst && mem_dq_oe && ram_drive) clash++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic wr, input logic [18:0] a, input logic [7:0] d);
    int n;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    n = 0;
    do begin @(negedge clk); n++; end while (!req_ack && n < 100);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [18:0] a, input logic [7:0] d);
    int cnt;
    bit ok;
    issue(1'b1, a, d);
    cnt = 0; ok = 1;
    while (!mem_we_n && cnt < 50) begin
      if (mem_ce_n || !mem_oe_n || !mem_dq_oe || mem_addr != a || mem_dq_out != d) ok = 0;
      cnt++;
      @(negedge clk);
    end
    check(ok, "R2 write strobes/addr/data", int'(ok), 1);
    check(cnt == WRC, "R2 write pulse width", cnt, WRC);
    check(!mem_ce_n && !mem_dq_oe, "R3 we rises with ce low, drive off",
          {mem_ce_n, mem_dq_oe}, 0);
  endtask

  task automatic do_read(input logic [18:0] a, input logic [7:0] exp);
    int n;
    issue(1'b0, a, 8'h00);
    check(mem_oe_n && !mem_dq_oe, "R4 gap cycle oe high drive off", {mem_oe_n, mem_dq_oe}, 2);
    n = 0;
    do begin @(negedge clk); n++; end while (!rd_valid && n < 50);
    check(n == AAC + 1, "R4 rd_valid latency", n, AAC + 1);
    check(rd_data == exp, "R4 read data", rd_data, exp);
    check(mem_oe_n && !mem_dq_oe, "R5 turnaround after read", {mem_oe_n, mem_dq_oe}, 2);
    @(negedge clk);
    check(!rd_valid, "R4 rd_valid single pulse", rd_valid, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int t_oe, t_oe_rise, t_drv;
    bit seen_ack2;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ack && !rd_valid,
          "R1 reset outputs", {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ack, rd_valid}, 6'b111000);

    // R1/R9: recovery lockout after reset with a request waiting
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00000; req_wdata = 8'h11;
    rst = 1'b0;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == 1) check(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !req_ack,
                        "R1 first cycle after reset", {mem_ce_n, req_ack}, 2'b10);
    end while (!req_ack && n < 100);
    req_valid = 1'b0;
    check(n == RCC + 2, "R1 first ack after reset", n, RCC + 2);
    while (!mem_we_n) @(negedge clk);

    // Vector table
    foreach (VECS[i]) begin
      if (VECS[i].wr) do_write(VECS[i].a, VECS[i].d);
      else            do_read(VECS[i].a, VECS[i].d);
    end

    // R6: idle, not in standby
    repeat (2) @(negedge clk);
    check(!mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R6 idle selected and quiet",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b0110);

    // R7/R5: read followed by a held write
    req_valid = 1'b1; req_write = 1'b0; req_addr = 19'h7FFFF;
    do @(negedge clk); while (!req_ack);
    req_write = 1'b1; req_addr = 19'h00ABC; req_wdata = 8'h96;
    n = 0; t_oe = 0; t_oe_rise = -1; t_drv = -1; seen_ack2 = 0;
    while (!seen_ack2 && n < 100) begin
      @(negedge clk); n++;
      if (!mem_oe_n) t_oe = 1;
      else if (t_oe == 1 && t_oe_rise < 0) t_oe_rise = n;
      if (mem_dq_oe && t_drv < 0) t_drv = n;
      if (rd_valid) check(rd_data == 8'hC3, "R4 read before held write", rd_data, 8'hC3);
      if (req_ack) seen_ack2 = 1;
    end
    req_valid = 1'b0;
    check(n == AAC + TAC + 2, "R7 held request accepted on return to idle", n, AAC + TAC + 2);
    check(t_drv - t_oe_rise >= TAC + 1, "R5 drive waits turnaround", t_drv - t_oe_rise, TAC + 1);
    while (!mem_we_n) @(negedge clk);
    do_read(19'h00ABC, 8'h96);

    // R8: standby in idle, request waiting
    standby = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00001; req_wdata = 8'h77;
    @(negedge clk);
    check(mem_ce_n && !req_ack, "R8 standby deselects before accepting",
          {mem_ce_n, req_ack}, 2'b10);
    n = 0;
    repeat (6) begin
      @(negedge clk);
      if (req_ack || !mem_ce_n) n++;
    end
    check(n == 0, "R8 nothing accepted in standby", n, 0);

    // R9: recovery lockout
    standby = 1'b0;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (n == RCC) check(mem_ce_n, "R9 still deselected in recovery", mem_ce_n, 1);
    end while (!req_ack && n < 100);
    req_valid = 1'b0;
    check(n == RCC + 2, "R9 first ack after standby", n, RCC + 2);
    while (!mem_we_n) @(negedge clk);
    do_read(19'h12345, 8'hE1);  // R8 retention
    do_read(19'h00001, 8'h77);

    check(clash == 0, "R5 no bus contention", clash, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule